// File: doc/BRIEF.md
# Page Buffered Program Sequencer

This block models the write path of a byte-wide nonvolatile store that is reprogrammed a whole page at a time. Qualified byte-load strobes carry an address and a data byte. The first accepted load opens a page cycle and fixes the page number. Later loads to that page land in a page buffer in any order. Each accepted load restarts an inactivity timer. When the timer runs out, the block starts an internal cycle of fixed length. That cycle erases the page to all ones and then programs the buffered bytes. At its last cycle the merged page image is written to the array in a single step.

A read port returns array bytes. For the whole internal cycle it returns a polling status built from the last accepted byte instead. A host can therefore poll bit 7 to find out when the cycle has finished. Both the inactivity timeout and the cycle length are parameters counted in clock cycles. The array size, page size and data width are also parameters.

Top module: `pbps_top`

## Requirements
- R1: An address splits into a page number, bits ADDR_W-1..PAGE_W, and a byte offset, bits PAGE_W-1..0. A byte loaded at page p, offset b reads back at address p*2^PAGE_W + b.
- R2: In the idle state, an accepted load opens a page cycle for its page. Bytes may then arrive in any order. If the same offset is loaded twice, the later value is stored.
- R3: Timing of the program cycle start:
  - The program cycle starts on the LOAD_TO-th clock edge after the last accepted load, provided no load is accepted in between.
  - A load accepted on that edge, or on any earlier one, restarts the wait.
- R4: While a page cycle is collecting, a load whose page number differs from the open page has no effect:
  - it stores nothing, on either page;
  - it does not restart the timer.
- R5: The internal cycle lasts exactly PROG_CYC clock cycles. Throughout it, rd_data = {~d[7], d[6:0]}, where d is the last accepted load byte.
- R6: When the cycle completes, every offset of the page that was loaded holds its loaded value, and every offset that was not loaded reads 8'hFF.
- R7: A page cycle leaves every other page unchanged.
- R8: Loads presented during the internal cycle are ignored. They change no array content and start no new cycle.
- R9: Reset returns the sequencer to idle at once, so reads show array data and not the polling status. A reset during collection or programming discards the pending page, and the array keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| ld_stb | input | 1 | Qualified byte-load event, one cycle per load |
| ld_addr | input | ADDR_W | Load address (page number and byte offset) |
| ld_data | input | DATA_W | Load data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array byte, or polling status while programming |

## Verification
The bench builds the block with ADDR_W=9, PAGE_W=6, LOAD_TO=5 and PROG_CYC=12. This gives 8 pages of 64 bytes, which is small enough to program every page with a permuted, partly skipped load order and then read back all 512 bytes against an arithmetic model. The short timeouts make the edges of both windows reachable cycle by cycle:
- a load on the final edge of the inactivity window;
- the first cycle and the last cycle of polling;
- foreign-page loads and loads during the busy phase;
- resets during collection and during programming.

// File: rtl/pbps_pkg.sv
package pbps_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_LOAD = 2'd1,
      PS_PROG = 2'd2
   } pbps_phase_e;

   function automatic int unsigned pbps_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pbps_page_buf.sv
// Page staging buffer: holds loaded bytes plus a fill mask; the image it
// presents already has the erase value on every slot that was not loaded.
module pbps_page_buf #(
   parameter int unsigned          PAGE_W    = 6,
   parameter int unsigned          DATA_W    = 8,
   parameter logic [DATA_W-1:0]    ERASE_VAL = '1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          wr,
   input  logic [PAGE_W-1:0]             wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [(1<<PAGE_W)*DATA_W-1:0] img
);
   localparam int unsigned SLOTS = 1 << PAGE_W;

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [SLOTS-1:0]  fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else begin
         if (clr) fill_q <= '0;
         if (wr)  fill_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr) slot_q[wr_idx] <= wr_data;
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign img[g*DATA_W +: DATA_W] = fill_q[g] ? slot_q[g] : ERASE_VAL;
   end
endmodule

// File: rtl/pbps_tick_cnt.sv
// Shared interval counter for the load window and the program cycle.
module pbps_tick_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pbps_array.sv
// Page-wide storage: one write of a whole page image, byte-wide async read.
module pbps_array #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAGE_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [ADDR_W-PAGE_W-1:0]      wr_page,
   input  logic [(1<<PAGE_W)*DATA_W-1:0] wr_img,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_byte
);
   localparam int unsigned SLOTS = 1 << PAGE_W;
   localparam int unsigned PAGES = 1 << (ADDR_W - PAGE_W);
   localparam int unsigned IMG_W = SLOTS * DATA_W;

   logic [IMG_W-1:0]  row_q [PAGES];
   logic [IMG_W-1:0]  rd_row;
   logic [DATA_W-1:0] row_bytes [SLOTS];

   always_ff @(posedge clk) begin
      if (we) row_q[wr_page] <= wr_img;
   end

   assign rd_row = row_q[rd_addr[ADDR_W-1:PAGE_W]];

   for (genvar g = 0; g < SLOTS; g++) begin : g_rd
      assign row_bytes[g] = rd_row[g*DATA_W +: DATA_W];
   end

   assign rd_byte = row_bytes[rd_addr[PAGE_W-1:0]];
endmodule

// File: rtl/pbps_top.sv
module pbps_top
   import pbps_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned PAGE_W   = 6,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned LOAD_TO  = 18750,
   parameter int unsigned PROG_CYC = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PG_AW = ADDR_W - PAGE_W;
   localparam int unsigned IMG_W = (1 << PAGE_W) * DATA_W;
   localparam int unsigned CNT_W = $clog2(pbps_max(LOAD_TO, PROG_CYC) + 1);
   localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_TO - 1);
   localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("pbps_top: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("pbps_top: DATA_W must be at least 2");
   end
   if (LOAD_TO < 1 || PROG_CYC < 1) begin : g_bad_time
      $error("pbps_top: LOAD_TO and PROG_CYC must be at least 1");
   end

   pbps_phase_e       phase_q;
   logic [PG_AW-1:0]  page_q;
   logic [DATA_W-1:0] last_q;
   logic [CNT_W-1:0]  tmr_cnt;
   logic [IMG_W-1:0]  page_img;
   logic [DATA_W-1:0] arr_byte;
   logic [PG_AW-1:0]  ld_page;
   logic              ld_ok;
   logic              load_exp;
   logic              prog_done;
   logic              busy;

   assign ld_page   = ld_addr[ADDR_W-1:PAGE_W];
   assign busy      = (phase_q == PS_PROG);
   assign ld_ok     = ld_stb && ((phase_q == PS_IDLE) ||
                                 ((phase_q == PS_LOAD) && (ld_page == page_q)));
   assign load_exp  = (phase_q == PS_LOAD) && !ld_ok && (tmr_cnt == LOAD_LAST);
   assign prog_done = busy && (tmr_cnt == PROG_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PS_IDLE;
         page_q  <= '0;
         last_q  <= '0;
      end else begin
         if (ld_ok) last_q <= ld_data;
         unique case (phase_q)
            PS_IDLE: if (ld_ok) begin
                        phase_q <= PS_LOAD;
                        page_q  <= ld_page;
                     end
            PS_LOAD: if (load_exp)  phase_q <= PS_PROG;
            PS_PROG: if (prog_done) phase_q <= PS_IDLE;
            default: phase_q <= PS_IDLE;
         endcase
      end
   end

   pbps_tick_cnt #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ld_ok || load_exp || prog_done),
      .en    (phase_q != PS_IDLE),
      .cnt   (tmr_cnt)
   );

   pbps_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .ERASE_VAL('1)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ld_ok && (phase_q == PS_IDLE)),
      .wr      (ld_ok),
      .wr_idx  (ld_addr[PAGE_W-1:0]),
      .wr_data (ld_data),
      .img     (page_img)
   );

   pbps_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .we      (prog_done),
      .wr_page (page_q),
      .wr_img  (page_img),
      .rd_addr (rd_addr),
      .rd_byte (arr_byte)
   );

   assign rd_data = busy ? {~last_q[DATA_W-1], last_q[DATA_W-2:0]} : arr_byte;
endmodule

// File: rtl/pbps_chk.sv
module pbps_chk
   import pbps_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned PAGE_W   = 6,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned LOAD_TO  = 18750,
   parameter int unsigned PROG_CYC = 1250000
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ld_stb,
   input logic [ADDR_W-1:0]        ld_addr,
   input logic                     ld_ok,
   input pbps_phase_e              phase,
   input logic [ADDR_W-PAGE_W-1:0] page_q,
   input logic [DATA_W-1:0]        last_q,
   input logic                     arr_we,
   input logic [DATA_W-1:0]        rd_data
);
   int unsigned gap_q;
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= 0;
         run_q <= 0;
      end else begin
         if (ld_ok)                 gap_q <= 0;
         else if (gap_q < LOAD_TO + 2) gap_q <= gap_q + 1;
         run_q <= (phase == PS_PROG) ? run_q + 1 : 0;
      end
   end

   // R3: programming begins exactly LOAD_TO edges after the last accepted load
   a_r3_expiry_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase == PS_PROG) |-> gap_q == LOAD_TO);

   // R5: busy phase length
   a_r5_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase == PS_PROG) |-> run_q == PROG_CYC);

   // R5: polling status does not move while busy
   a_r5_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PS_PROG) && $past(phase == PS_PROG) |-> $stable(rd_data));

   // R4: a foreign-page load during collection changes no sequencer state
   a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PS_LOAD) && ld_stb && (ld_addr[ADDR_W-1:PAGE_W] != page_q)
      |=> $stable(page_q) && $stable(last_q));

   // R8: nothing is absorbed while busy
   a_r8_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PS_PROG) |=> $stable(page_q) && $stable(last_q));

   // R6: the commit happens on the final busy cycle and ends the cycle
   a_r6_commit_last: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (phase == PS_PROG) && (run_q == PROG_CYC - 1));

   a_r6_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> phase == PS_IDLE);
endmodule

bind pbps_top pbps_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
   .LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_stb  (ld_stb),
   .ld_addr (ld_addr),
   .ld_ok   (ld_ok),
   .phase   (phase_q),
   .page_q  (page_q),
   .last_q  (last_q),
   .arr_we  (prog_done),
   .rd_data (rd_data)
);

// File: tb/tb_pbps_top.sv
`timescale 1ns/1ps
module tb_pbps_top;
   localparam int AW  = 9;
   localparam int PW  = 6;
   localparam int NPG = 1 << (AW - PW);
   localparam int LTO = 5;
   localparam int PCY = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_stb = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [7:0]    ld_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_mem [1 << AW];

   always #4 clk = ~clk;

   pbps_top #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(8), .LOAD_TO(LTO), .PROG_CYC(PCY)) dut (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr),
      .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [AW-1:0] mk(input int p, input int b);
      return AW'(p * 64 + b);
   endfunction

   function automatic logic [7:0] fdat(input int p, input int b);
      return 8'((p * 53 + b * 7 + 53) & 255);
   endfunction

   function automatic logic [7:0] pollv(input logic [7:0] d);
      return {~d[7], d[6:0]};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
      n_run++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   // caller sits at a negedge; the load is taken on the next posedge
   task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
      ld_stb = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_stb = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [AW-1:0] a);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp_mem[a]);
   endtask

   task automatic check_page(input string tag, input int p);
      for (int b = 0; b < 64; b++) read_chk(tag, mk(p, b));
   endtask

   task automatic sweep_page(input int p);
      logic [7:0] pg [64];
      logic [7:0] last;
      int b0;
      for (int b = 0; b < 64; b++) pg[b] = 8'hFF;
      b0 = (p * 3) % 64;
      load(mk(p, b0), ~fdat(p, b0));
      pg[b0] = ~fdat(p, b0);
      last = ~fdat(p, b0);
      for (int i = 0; i < 64; i++) begin
         int b;
         b = (i * 37 + p * 11) % 64;
         if ((b + p) % 5 != 0) begin
            load(mk(p, b), fdat(p, b));
            pg[b] = fdat(p, b);
            last = fdat(p, b);
         end
      end
      repeat (LTO) @(negedge clk);
      chk("R5 poll status", rd_data, pollv(last));
      repeat (PCY) @(negedge clk);
      for (int b = 0; b < 64; b++) exp_mem[mk(p, b)] = pg[b];
      for (int b = 0; b < 64; b++) begin
         rd_addr = mk(p, b);
         #1;
         if ((b + p) % 5 != 0) chk("R1 R2 loaded byte", rd_data, pg[b]);
         else if (b == b0)     chk("R2 single load kept", rd_data, pg[b]);
         else                  chk("R6 unloaded byte FF", rd_data, 8'hFF);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [AW-1:0] xa, xb, fa, ya;
      logic [7:0]    dd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep over every page
      for (int p = 0; p < NPG; p++) sweep_page(p);
      for (int p = 0; p < NPG; p++) check_page("R7 other pages intact", p);

      // R3: a load on the last edge of the window extends collection
      xa = mk(2, 5); xb = mk(2, 40);
      dd = exp_mem[xb];
      rd_addr = xb;
      load(xa, 8'h3C);
      repeat (LTO - 1) @(negedge clk);
      load(xb, dd);
      repeat (LTO - 1) @(negedge clk);
      chk("R3 not yet programming", rd_data, dd);
      @(negedge clk);
      chk("R3 programming starts on time", rd_data, pollv(dd));
      repeat (PCY - 1) @(negedge clk);
      chk("R5 last busy cycle polls", rd_data, pollv(dd));
      @(negedge clk);
      for (int b = 0; b < 64; b++) exp_mem[mk(2, b)] = 8'hFF;
      exp_mem[xa] = 8'h3C; exp_mem[xb] = dd;
      chk("R5 data after completion", rd_data, dd);
      check_page("R6 page after extended load", 2);

      // R4 then R8: foreign load does not extend, busy load is dropped
      xa = mk(5, 17); fa = mk(6, 9); ya = mk(1, 33);
      dd = exp_mem[fa];
      rd_addr = fa;
      load(xa, dd);
      @(negedge clk);
      load(fa, ~dd);
      repeat (LTO - 3) @(negedge clk);
      chk("R4 foreign load no store", rd_data, dd);
      @(negedge clk);
      chk("R4 timer not restarted", rd_data, pollv(dd));
      load(ya, ~exp_mem[ya]);
      chk("R8 poll unaffected by busy load", rd_data, pollv(dd));
      repeat (PCY - 1) @(negedge clk);
      for (int b = 0; b < 64; b++) exp_mem[mk(5, b)] = 8'hFF;
      exp_mem[xa] = dd;
      repeat (LTO + PCY + 4) @(negedge clk);
      check_page("R6 page after foreign load", 5);
      check_page("R4 foreign page unchanged", 6);
      check_page("R8 busy load ignored", 1);

      // R9: reset during collection
      load(mk(3, 0), 8'h11);
      load(mk(3, 1), 8'h22);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (LTO + PCY + 4) @(negedge clk);
      check_page("R9 reset in collection", 3);

      // R9: reset during programming
      rd_addr = mk(4, 7);
      dd = exp_mem[mk(4, 7)];
      load(mk(4, 7), dd);
      repeat (LTO + 2) @(negedge clk);
      chk("R9 busy before reset", rd_data, pollv(dd));
      rst_n = 1'b0;
      #1;
      chk("R9 reset leaves polling", rd_data, dd);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (LTO + PCY + 4) @(negedge clk);
      check_page("R9 reset in programming", 4);

      for (int p = 0; p < NPG; p++) check_page("R7 final array", p);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule